// File: doc/BRIEF.md
# Converter Result Readout Port

This block is the digital output side of a 16-bit data converter. A conversion sequencer hands it each new result with a one-cycle load strobe, and the block keeps that result in a holding register. The host then reads the result over a shared set of tristate pins, either as one parallel word or as a serial bit stream. A mode input picks parallel or serial. In serial mode, four pins from the middle of the bus take on the roles of data out, bit clock, frame sync and overrun flag, and the other pins are released.

The serial port can run in one of two ways. In master mode the block produces the bit clock itself, divided down from the system clock, and marks the frame with a sync pin of selectable polarity. In slave mode the host drives the bit clock into the block, and an input picks which clock edge moves the data. A format input picks straight binary or two's complement output. Chip select and read, both active low, gate every pin. In slave mode, if a new result arrives before the host has finished clocking out the old one, the old read is dropped and an error pulse is raised.

Top module: `conv_readout_port`

## Requirements
- R1: With `ser_mode` low and both `cs_n` and `rd_n` low, `data_io[15:0]` drives the coded result, and the most recent `ld_strobe` sets that result from `ld_data`.
- R2: With `fmt_twos` low, the coded result equals the stored value. With it high, bit 15 is inverted and the other bits are unchanged (straight binary to two's complement).
- R3: While `cs_n` or `rd_n` is high, no pin of `data_io` is driven.
- R4: In serial mode, the pins are assigned as follows: pin 8 is serial data, pin 9 is the bit clock, pin 10 is frame sync (master mode only) and pin 11 is the overrun flag (slave mode only). Pins 0 to 7 and 12 to 15 are released.
- R5: In master mode (`ext_clk` low), the block drives pin 9 itself. A read starts on the first clock edge at which the bus is enabled. It produces exactly 16 bit periods of 4*QTR_CYC system cycles each. In each period the clock is low for the first QTR_CYC cycles, high for the next 2*QTR_CYC cycles, and low for the last QTR_CYC cycles. After the 16 periods the clock stays low until the bus is released.
- R6: Serial data leaves most significant bit first. In master mode, each bit holds steady over its whole period, so it is valid on both clock edges. Once the 16 bits are out, pin 8 stays low.
- R7: In master mode, pin 10 is at its active level during the 16 bit periods and at its inactive level otherwise. The active level is high when `sync_inv` is low and low when `sync_inv` is high.
- R8: In slave mode, pin 9 is an input, gated by `cs_n`. The update edge is the rising edge when `clk_inv` is low and the falling edge when `clk_inv` is high. Each update edge moves the next bit, MSB first, onto pin 8 within 3 system cycles. Sample edges that come before the first update edge are ignored. The read is complete after the 16th sample edge.
- R9: In slave mode, a `ld_strobe` that arrives during an unfinished read raises pin 11 for exactly one cycle, and the rest of that read is dropped: pin 8 stays low. A load after the read is complete raises no pulse.
- R10: Reset clears the stored result and the shift registers, and returns both serial engines to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_strobe | input | 1 | One-cycle strobe that stores a new result |
| ld_data | input | 16 | New result, straight binary |
| ser_mode | input | 1 | 0 = parallel readout, 1 = serial readout |
| fmt_twos | input | 1 | 1 = two's complement output coding |
| ext_clk | input | 1 | 1 = bit clock supplied by the host (slave) |
| clk_inv | input | 1 | Slave mode: 1 = data moves on the falling edge |
| sync_inv | input | 1 | Master mode: 1 = frame sync active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read enable, active low |
| data_io | inout | 16 | Shared parallel bus and serial pins |

## Verification
The checker assumes that the mode, format, polarity and edge inputs stay fixed while a serial read is in progress. It also assumes that `ld_strobe` lasts one cycle. The bench changes these inputs only while the bus is released, and it pulses loads for a single cycle. In slave mode the host clock is taken to be much slower than the system clock. The bench holds each level of that clock for eight system cycles, which is well above the three-cycle synchronizer delay, so every edge is detected once. Released pins are checked by loading all-ones data and confirming that the pin does not read back as a one.

// File: rtl/conv_rd_pkg.sv
package conv_rd_pkg;
   typedef enum logic [1:0] {
      RD_IDLE  = 2'd0,
      RD_SHIFT = 2'd1,
      RD_HOLD  = 2'd2
   } rd_state_t;
endpackage

// File: rtl/conv_code_fmt.sv
module conv_code_fmt #(
   parameter int W = 16
) (
   input  logic [W-1:0] raw,
   input  logic         twos,
   output logic [W-1:0] code
);
   // Offset binary to two's complement is a flip of the sign bit only.
   assign code = {raw[W-1] ^ twos, raw[W-2:0]};
endmodule

// File: rtl/conv_int_ser.sv
module conv_int_ser
   import conv_rd_pkg::*;
#(
   parameter int W   = 16,
   parameter int QTR = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic         bus_en,
   input  logic [W-1:0] word,
   output logic         sclk,
   output logic         sdo,
   output logic         active
);
   localparam int PER   = 4 * QTR;
   localparam int PH_W  = (PER > 1) ? $clog2(PER) : 1;
   localparam int BIT_W = $clog2(W);
   localparam logic [PH_W-1:0]  PH_LAST = PH_W'(PER - 1);
   localparam logic [PH_W-1:0]  PH_RISE = PH_W'(QTR);
   localparam logic [PH_W-1:0]  PH_FALL = PH_W'(3 * QTR);
   localparam logic [BIT_W-1:0] BIT_END = BIT_W'(W - 1);

   rd_state_t        st;
   logic [PH_W-1:0]  ph;
   logic [BIT_W-1:0] bc;
   logic [W-1:0]     sh;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= RD_IDLE;
         ph <= '0;
         bc <= '0;
         sh <= '0;
      end else if (!bus_en) begin
         st <= RD_IDLE;
         ph <= '0;
         bc <= '0;
      end else begin
         case (st)
            RD_IDLE: begin
               if (go) begin
                  st <= RD_SHIFT;
                  sh <= word;
                  ph <= '0;
                  bc <= '0;
               end
            end
            RD_SHIFT: begin
               if (ph == PH_LAST) begin
                  ph <= '0;
                  sh <= {sh[W-2:0], 1'b0};
                  if (bc == BIT_END) st <= RD_HOLD;
                  else               bc <= bc + 1'b1;
               end else begin
                  ph <= ph + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   // Bit changes at phase 0, clock edges sit a quarter period away on each side.
   assign active = (st == RD_SHIFT);
   assign sclk   = active && (ph >= PH_RISE) && (ph < PH_FALL);
   assign sdo    = active && sh[W-1];
endmodule

// File: rtl/conv_ext_ser.sv
module conv_ext_ser
   import conv_rd_pkg::*;
#(
   parameter int W        = 16,
   parameter int SYNC_LEN = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         go,
   input  logic         bus_en,
   input  logic         sck_pin,
   input  logic         clk_inv,
   input  logic         ld_strobe,
   input  logic [W-1:0] word,
   output logic         sdo,
   output logic         err
);
   localparam int CNT_W = $clog2(W + 1);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(W - 1);

   logic [SYNC_LEN:0] sq;

   for (genvar i = 0; i <= SYNC_LEN; i++) begin : g_sync
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sq[i] <= 1'b0;
            else        sq[i] <= sck_pin;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) sq[i] <= 1'b0;
            else        sq[i] <= sq[i-1];
      end
   end

   logic rise_e, fall_e, upd_e, smp_e;
   assign rise_e = sq[SYNC_LEN-1] & ~sq[SYNC_LEN];
   assign fall_e = ~sq[SYNC_LEN-1] & sq[SYNC_LEN];
   assign upd_e  = clk_inv ? fall_e : rise_e;
   assign smp_e  = clk_inv ? rise_e : fall_e;

   rd_state_t        st;
   logic [W-1:0]     sh;
   logic [CNT_W-1:0] upd, smp;
   logic             sdo_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= RD_IDLE;
         sh    <= '0;
         upd   <= '0;
         smp   <= '0;
         sdo_r <= 1'b0;
      end else if (!bus_en) begin
         st <= RD_IDLE;
      end else begin
         case (st)
            RD_IDLE: begin
               if (go) begin
                  st    <= RD_SHIFT;
                  sh    <= word;
                  upd   <= '0;
                  smp   <= '0;
                  sdo_r <= 1'b0;
               end
            end
            RD_SHIFT: begin
               if (ld_strobe) begin
                  st <= RD_HOLD;
               end else begin
                  if (upd_e && (upd != CNT_FULL)) begin
                     sdo_r <= sh[W-1];
                     sh    <= {sh[W-2:0], 1'b0};
                     upd   <= upd + 1'b1;
                  end
                  if (smp_e && (smp < upd)) begin
                     smp <= smp + 1'b1;
                     if (smp == CNT_LAST) st <= RD_HOLD;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) err <= 1'b0;
      else        err <= bus_en && (st == RD_SHIFT) && ld_strobe;

   assign sdo = (st == RD_SHIFT) && sdo_r;
endmodule

// File: rtl/conv_readout_port.sv
module conv_readout_port
   import conv_rd_pkg::*;
#(
   parameter int DATA_W   = 16,
   parameter int QTR_CYC  = 1,
   parameter int SYNC_LEN = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ld_strobe,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ser_mode,
   input  logic              fmt_twos,
   input  logic              ext_clk,
   input  logic              clk_inv,
   input  logic              sync_inv,
   input  logic              cs_n,
   input  logic              rd_n,
   inout  wire  [DATA_W-1:0] data_io
);
   localparam int SDO_PIN  = DATA_W / 2;
   localparam int SCK_PIN  = SDO_PIN + 1;
   localparam int SYNC_PIN = SDO_PIN + 2;
   localparam int ERR_PIN  = SDO_PIN + 3;

   if (DATA_W < 8 || (DATA_W % 2) != 0) begin : g_bad_width
      $error("DATA_W must be even and at least 8");
   end
   if (QTR_CYC < 1) begin : g_bad_qtr
      $error("QTR_CYC must be at least 1");
   end
   if (SYNC_LEN < 1) begin : g_bad_sync
      $error("SYNC_LEN must be at least 1");
   end

   logic [DATA_W-1:0] result, code;
   logic              bus_en;
   logic              int_sclk, int_sdo, int_act;
   logic              ext_sdo, ext_err;
   logic [DATA_W-1:0] pin_oe, pin_val;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)         result <= '0;
      else if (ld_strobe) result <= ld_data;

   assign bus_en = !cs_n && !rd_n;

   conv_code_fmt #(.W(DATA_W)) i_fmt (
      .raw  (result),
      .twos (fmt_twos),
      .code (code)
   );

   conv_int_ser #(.W(DATA_W), .QTR(QTR_CYC)) i_int (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (bus_en && ser_mode && !ext_clk),
      .bus_en (bus_en),
      .word   (code),
      .sclk   (int_sclk),
      .sdo    (int_sdo),
      .active (int_act)
   );

   conv_ext_ser #(.W(DATA_W), .SYNC_LEN(SYNC_LEN)) i_ext (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (bus_en && ser_mode && ext_clk),
      .bus_en    (bus_en),
      .sck_pin   (data_io[SCK_PIN] && !cs_n),
      .clk_inv   (clk_inv),
      .ld_strobe (ld_strobe),
      .word      (code),
      .sdo       (ext_sdo),
      .err       (ext_err)
   );

   always_comb begin
      pin_oe  = '0;
      pin_val = '0;
      if (bus_en) begin
         if (!ser_mode) begin
            pin_oe  = '1;
            pin_val = code;
         end else begin
            pin_oe[SDO_PIN]  = 1'b1;
            pin_val[SDO_PIN] = ext_clk ? ext_sdo : int_sdo;
            if (!ext_clk) begin
               pin_oe[SCK_PIN]   = 1'b1;
               pin_val[SCK_PIN]  = int_sclk;
               pin_oe[SYNC_PIN]  = 1'b1;
               pin_val[SYNC_PIN] = int_act ^ sync_inv;
            end else begin
               pin_oe[ERR_PIN]  = 1'b1;
               pin_val[ERR_PIN] = ext_err;
            end
         end
      end
   end

   for (genvar p = 0; p < DATA_W; p++) begin : g_pad
      assign data_io[p] = pin_oe[p] ? pin_val[p] : 1'bz;
   end
endmodule

// File: rtl/conv_readout_chk.sv
module conv_readout_chk #(
   parameter int W = 16
) (
   input logic         clk,
   input logic         rst_n,
   input logic         cs_n,
   input logic         rd_n,
   input logic         ser_mode,
   input logic         ld_strobe,
   input logic [W-1:0] oe,
   input logic         isclk,
   input logic         isdo,
   input logic         iact,
   input logic         eerr
);
   logic bus_en;
   assign bus_en = !cs_n && !rd_n;

   // R3
   bus_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_en |-> (oe == '0));

   // R4
   ser_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ser_mode |-> (oe[W-1:W/2+4] == '0 && oe[W/2-1:0] == '0));

   // R6
   rise_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(isclk) |-> $stable(isdo));

   // R6
   fall_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(isclk) |-> $stable(isdo));

   // R7
   clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      isclk |-> iact);

   // R9
   err_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eerr |=> !eerr);

   // R9
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      eerr |-> $past(ld_strobe));
endmodule

bind conv_readout_port conv_readout_chk #(.W(DATA_W)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cs_n      (cs_n),
   .rd_n      (rd_n),
   .ser_mode  (ser_mode),
   .ld_strobe (ld_strobe),
   .oe        (pin_oe),
   .isclk     (int_sclk),
   .isdo      (int_sdo),
   .iact      (int_act),
   .eerr      (ext_err)
);

// File: tb/test_conv_readout_port.sv
module test_conv_readout_port;
   localparam int W   = 16;
   localparam int Q   = 1;
   localparam int PER = 4 * Q;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         ld = 1'b0;
   logic [W-1:0] ldd = '0;
   logic         ser = 1'b0, twos = 1'b0, ext = 1'b0, cinv = 1'b0, sinv = 1'b0;
   logic         cs_n = 1'b1, rd_n = 1'b1;
   logic         sck = 1'b0, sck_en = 1'b0;
   wire  [W-1:0] dio;
   int           total = 0, bad = 0;

   assign dio[9] = sck_en ? sck : 1'bz;

   always #10 clk = ~clk;

   conv_readout_port #(.DATA_W(W), .QTR_CYC(Q)) i_conv_readout_port (
      .clk(clk), .rst_n(rst_n), .ld_strobe(ld), .ld_data(ldd),
      .ser_mode(ser), .fmt_twos(twos), .ext_clk(ext), .clk_inv(cinv),
      .sync_inv(sinv), .cs_n(cs_n), .rd_n(rd_n), .data_io(dio)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic load(input logic [W-1:0] v);
      ld = 1'b1; ldd = v;
      @(negedge clk);
      ld = 1'b0;
   endtask

   function automatic logic [W-1:0] coded(input logic [W-1:0] v, input logic t);
      return t ? (v ^ 16'h8000) : v;
   endfunction

   // Counts pins in mask that read back as 1 (released pins must not).
   function automatic int driven_ones(input logic [W-1:0] mask);
      int n = 0;
      for (int i = 0; i < W; i++) if (mask[i] && dio[i] === 1'b1) n++;
      return n;
   endfunction

   task automatic int_read(input logic [W-1:0] raw, input logic t, input logic si);
      logic [W-1:0] c;
      ser = 1'b1; ext = 1'b0; twos = t; sinv = si; sck_en = 1'b0;
      load(raw);
      c = coded(raw, t);
      cs_n = 1'b0; rd_n = 1'b0;
      for (int k = 0; k <= 16 * PER; k++) begin
         logic esck, esdo, esync;
         @(negedge clk);
         if (k < 16 * PER) begin
            esck  = ((k % PER) >= Q) && ((k % PER) < 3 * Q);
            esdo  = c[W-1-(k / PER)];
            esync = !si;
         end else begin
            esck = 1'b0; esdo = 1'b0; esync = si;
         end
         // R5 R6 R7 : {clock, data, sync}
         chk({dio[9], dio[8], dio[10]} === {esck, esdo, esync}, "R5 R6 R7 master frame",
             int'({dio[9], dio[8], dio[10]}), int'({esck, esdo, esync}));
         if (k == 0)
            chk(driven_ones(16'hF0FF & c) == 0, "R4 master released pins",
                driven_ones(16'hF0FF & c), 0);
      end
      cyc(3);
      chk(dio[9] === 1'b0 && dio[10] === si, "R5 hold after frame",
          int'({dio[9], dio[10]}), int'({1'b0, si}));
      cs_n = 1'b1; rd_n = 1'b1;
      cyc(2);
   endtask

   task automatic ext_read(input logic [W-1:0] raw, input logic t, input logic ci,
                           input int nbits, input bit overrun);
      logic [W-1:0] c;
      logic         upl;
      ser = 1'b1; ext = 1'b1; twos = t; cinv = ci; sck_en = 1'b1; sck = 1'b0;
      load(raw);
      c = coded(raw, t);
      upl = !ci;
      cyc(4);
      cs_n = 1'b0; rd_n = 1'b0;
      cyc(2);
      chk(driven_ones(16'hF4FF) == 0, "R4 slave released pins", driven_ones(16'hF4FF), 0);
      for (int b = 0; b < nbits; b++) begin
         sck = !upl; cyc(8);
         sck = upl;  cyc(7);
         chk(dio[8] === c[W-1-b], "R8 slave bit", int'(dio[8]), int'(c[W-1-b]));
         cyc(1);
      end
      if (!overrun) begin
         sck = !upl; cyc(8);
      end
      load(~raw);
      chk(dio[11] === overrun, "R9 flag after load", int'(dio[11]), int'(overrun));
      cyc(1);
      chk(dio[11] === 1'b0, "R9 flag one cycle", int'(dio[11]), 0);
      if (overrun) begin
         for (int b = 0; b < 2; b++) begin
            sck = !upl; cyc(8);
            sck = upl;  cyc(7);
            chk(dio[8] === 1'b0, "R9 dropped read", int'(dio[8]), 0);
            cyc(1);
         end
      end
      cs_n = 1'b1; rd_n = 1'b1;
      sck = 1'b0;
      cyc(2);
      sck_en = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      cyc(3);
      rst_n = 1'b1;
      cyc(1);
      // R10 reset state: cleared result on the parallel bus
      cs_n = 1'b0; rd_n = 1'b0;
      cyc(1);
      chk(dio === 16'h0000, "R10 reset result", int'(dio), 0);

      // R1 parallel readout
      load(16'h1234);
      chk(dio === 16'h1234, "R1 parallel", int'(dio), 16'h1234);
      load(16'h7FFE);
      chk(dio === 16'h7FFE, "R1 parallel second load", int'(dio), 16'h7FFE);
      // R2 coding
      twos = 1'b1;
      cyc(1);
      chk(dio === 16'hFFFE, "R2 twos complement", int'(dio), 16'hFFFE);
      load(16'h8001);
      chk(dio === 16'h0001, "R2 twos sign flip", int'(dio), 16'h0001);
      twos = 1'b0;
      cyc(1);
      chk(dio === 16'h8001, "R2 binary pass", int'(dio), 16'h8001);

      // R3 bus gating
      load(16'hFFFF);
      cs_n = 1'b1; rd_n = 1'b0;
      cyc(1);
      chk(driven_ones(16'hFFFF) == 0, "R3 cs high releases", driven_ones(16'hFFFF), 0);
      cs_n = 1'b0; rd_n = 1'b1;
      cyc(1);
      chk(driven_ones(16'hFFFF) == 0, "R3 rd high releases", driven_ones(16'hFFFF), 0);
      rd_n = 1'b1; cs_n = 1'b1;
      cyc(2);

      // R5 R6 R7 master readout, both sync polarities and both codings
      int_read(16'hA5C3, 1'b0, 1'b0);
      int_read(16'h0F96, 1'b1, 1'b1);
      int_read(16'hFFFF, 1'b0, 1'b0);

      // R8 slave readout, both edge choices; R9 load after completion
      ext_read(16'hC35A, 1'b0, 1'b0, 16, 1'b0);
      ext_read(16'h1E87, 1'b1, 1'b1, 16, 1'b0);
      // R9 overrun mid-read
      ext_read(16'hB6D9, 1'b0, 1'b0, 4, 1'b1);
      ext_read(16'h5AA5, 1'b0, 1'b1, 7, 1'b1);

      // R10 reset during a master read
      ser = 1'b1; ext = 1'b0;
      load(16'hBEEF);
      cs_n = 1'b0; rd_n = 1'b0;
      cyc(10);
      rst_n = 1'b0;
      cyc(2);
      rst_n = 1'b1;
      cs_n = 1'b1; rd_n = 1'b1; ser = 1'b0;
      cyc(1);
      cs_n = 1'b0; rd_n = 1'b0;
      cyc(1);
      chk(dio === 16'h0000, "R10 reset clears result", int'(dio), 0);
      cs_n = 1'b1; rd_n = 1'b1;
      cyc(2);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule